// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Datapath

This block is the storage and data path behind a pipelined synchronous SRAM that needs no idle cycle when the bus turns between reads and writes. A sequencer in front of it decodes each bus slot into a cycle type and a word address. It also passes four active-low lane write enables. The datapath accepts one such slot on every enabled clock edge. A read returns its word on a registered output bus two enabled edges later. The data for a write arrives on the input bus two enabled edges after its address, so the address and lane enables wait in a short pipeline until the data catches up. The write is then committed to the register array on the following enabled edge.

Writes therefore stay pending for several cycles. A forwarding network lets a read see every write that was issued before it, lane by lane, whether that write has reached the array or not. A clock-enable input freezes every stage at once. The output-enable input only gates the drive indication that goes to the pads.

Top module: `zbt_sram_core`

## Requirements
- R1: The `op` encoding is 00 idle/deselect, 01 read, 10 write and 11 treated as idle. A read sampled on enabled edge k puts the word at its address into `rdata` after enabled edge k+2. With `oe_n` low, it raises `rdata_drive` for that cycle.
- R2: For a write sampled on enabled edge k, `wdata` is taken on enabled edge k+2. Bit i of `bwe_n` (active low) selects lane i, which is bits [9i+8:9i] of the word. Only the selected lanes change in memory.
- R3: A write with all four `bwe_n` bits high uses its slot and alters no memory word.
- R4: A read returns the result of every write issued before it, whether it follows that write directly or after one, two or more other slots. No idle slot is needed between them.
- R5: For a pending write to the read address, each lane returns the pending data when that lane was enabled. Otherwise it returns the older content.
- R6: When two pending writes target the read address, the newer write decides each lane it enabled.
- R7: While `clk_en` is low, all inputs are ignored. Pending writes, the array and the output registers all hold their values.
- R8: After an output slot that carried a write or idle cycle, `rdata_drive` is low.
- R9: A read issued while `oe_n` is high loads `rdata` but leaves `rdata_drive` low. `oe_n` never changes the data held in the pipeline.
- R10: After reset, `rdata_drive` is low and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | High lets the edge advance the pipeline; low stalls |
| op | input | 2 | Decoded cycle type of the slot |
| addr | input | AW | Word address of the slot |
| bwe_n | input | LANES | Active-low lane write enables, sampled with the address |
| wdata | input | W | Late write data, two enabled edges after its address |
| oe_n | input | 1 | Active-low output enable, gates the drive indication only |
| rdata | output | W | Registered read data |
| rdata_drive | output | 1 | High when the pads should drive `rdata` |

## Verification
The hardest state to reach is a read whose address matches two writes still in flight, with different lane masks and a stall sitting between them. In that state the older write is merged at the array-read stage and the newer one at the output stage. The stimulus issues back-to-back writes to one address with overlapping masks and reads that address immediately. It also sweeps the gap between write and read from zero to three slots, so each forwarding point and the plain array path are each exercised alone. A randomized phase then packs mixed reads, writes, aborts and stalls onto eight addresses, so that same-address overlaps occur often.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

endpackage

// File: rtl/zbt_lane_merge.sv
module zbt_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] base_i,
    input  logic                    hit_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [LANES*LANE_W-1:0] fwd_i,
    output logic [LANES*LANE_W-1:0] merged_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged_o[l*LANE_W +: LANE_W] = (hit_i && mask_i[l])
                                              ? fwd_i[l*LANE_W +: LANE_W]
                                              : base_i[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           wr_addr_i,
    input  logic [LANES-1:0]        wr_mask_i,
    input  logic [LANES*LANE_W-1:0] wr_data_i,
    input  logic [AW-1:0]           rd_addr_i,
    output logic [LANES*LANE_W-1:0] rd_data_o
);

    localparam int W = LANES * LANE_W;

    typedef logic [DEPTH-1:0][W-1:0] array_t;

    array_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (en_i && wr_en_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_mask_i[l]) begin
                    mem_d[wr_addr_i][l*LANE_W +: LANE_W] = wr_data_i[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R3: a commit with no lane selected leaves the array untouched
    assert_abort_keeps_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_en_i && (wr_mask_i == '0)) |=> $stable(mem_q));

    // R7: a stalled edge leaves the array untouched
    assert_stall_keeps_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(mem_q));

endmodule

// File: rtl/zbt_ctrl_pipe.sv
module zbt_ctrl_pipe
    import zbt_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  op_e                     op_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANES-1:0]        bwe_n_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    // array word already merged with the commit slot, for the slot in stage 1
    input  logic [LANES*LANE_W-1:0] s1_merged_i,
    // stage-2 raw word merged with the commit slot
    input  logic [LANES*LANE_W-1:0] s2_merged_i,
    output logic [AW-1:0]           s1_addr_o,
    output logic [AW-1:0]           s2_addr_o,
    output logic [LANES*LANE_W-1:0] s2_raw_o,
    output logic                    cb_vld_o,
    output logic [AW-1:0]           cb_addr_o,
    output logic [LANES-1:0]        cb_mask_o,
    output logic [LANES*LANE_W-1:0] cb_data_o,
    output logic                    out_rd_o,
    output logic [LANES*LANE_W-1:0] out_data_o
);

    localparam int W = LANES * LANE_W;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] mask;
    } slot_t;

    typedef struct packed {
        slot_t            s1;
        slot_t            s2;
        logic [W-1:0]     raw;
        logic             cb_vld;
        logic [AW-1:0]    cb_addr;
        logic [LANES-1:0] cb_mask;
        logic [W-1:0]     cb_data;
        logic             out_rd;
        logic [W-1:0]     out_data;
    } pipe_t;

    pipe_t p_d, p_q;
    slot_t in_slot;

    always_comb begin
        in_slot.rd   = (op_i == OP_READ);
        in_slot.wr   = (op_i == OP_WRITE);
        in_slot.addr = addr_i;
        in_slot.mask = ~bwe_n_i;

        p_d = p_q;
        if (en_i) begin
            p_d.s1      = in_slot;
            p_d.s2      = p_q.s1;
            p_d.raw     = s1_merged_i;
            p_d.cb_vld  = p_q.s2.wr;
            p_d.cb_addr = p_q.s2.addr;
            p_d.cb_mask = p_q.s2.wr ? p_q.s2.mask : '0;
            p_d.cb_data = wdata_i;
            p_d.out_rd  = p_q.s2.rd;
            if (p_q.s2.rd) begin
                p_d.out_data = s2_merged_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign s1_addr_o  = p_q.s1.addr;
    assign s2_addr_o  = p_q.s2.addr;
    assign s2_raw_o   = p_q.raw;
    assign cb_vld_o   = p_q.cb_vld;
    assign cb_addr_o  = p_q.cb_addr;
    assign cb_mask_o  = p_q.cb_mask;
    assign cb_data_o  = p_q.cb_data;
    assign out_rd_o   = p_q.out_rd;
    assign out_data_o = p_q.out_data;

    // R1: a read in stage 2 reaches the output register on the next enabled edge
    assert_read_reaches_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && p_q.s2.rd) |=> out_rd_o);

    // R2: the write in stage 2 takes the data bus on the next enabled edge
    assert_late_data_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && p_q.s2.wr) |=> (cb_vld_o && (cb_data_o == $past(wdata_i))));

    // R7: a stalled edge holds every stage
    assert_stall_holds_pipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(p_q));

    // R8: a write slot leaves the output undriven
    assert_write_slot_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !p_q.s2.rd) |=> !out_rd_o);

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int W      = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [1:0]       op,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bwe_n,
    input  logic [W-1:0]     wdata,
    input  logic             oe_n,
    output logic [W-1:0]     rdata,
    output logic             rdata_drive
);

    logic [AW-1:0]    s1_addr, s2_addr, cb_addr;
    logic [W-1:0]     s2_raw, cb_data, out_data;
    logic [W-1:0]     arr_word, s1_merged, s2_merged;
    logic [LANES-1:0] cb_mask;
    logic             cb_vld, out_rd;
    logic             s1_hit, s2_hit;

    zbt_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (clk_en),
        .wr_en_i  (cb_vld),
        .wr_addr_i(cb_addr),
        .wr_mask_i(cb_mask),
        .wr_data_i(cb_data),
        .rd_addr_i(s1_addr),
        .rd_data_o(arr_word)
    );

    assign s1_hit = cb_vld && (cb_addr == s1_addr);
    assign s2_hit = cb_vld && (cb_addr == s2_addr);

    // older pending write folded in while reading the array
    zbt_lane_merge #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_merge_early (
        .base_i  (arr_word),
        .hit_i   (s1_hit),
        .mask_i  (cb_mask),
        .fwd_i   (cb_data),
        .merged_o(s1_merged)
    );

    // newer pending write folded in at the output register
    zbt_lane_merge #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_merge_late (
        .base_i  (s2_raw),
        .hit_i   (s2_hit),
        .mask_i  (cb_mask),
        .fwd_i   (cb_data),
        .merged_o(s2_merged)
    );

    zbt_ctrl_pipe #(
        .AW    (AW),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (clk_en),
        .op_i       (op_e'(op)),
        .addr_i     (addr),
        .bwe_n_i    (bwe_n),
        .wdata_i    (wdata),
        .s1_merged_i(s1_merged),
        .s2_merged_i(s2_merged),
        .s1_addr_o  (s1_addr),
        .s2_addr_o  (s2_addr),
        .s2_raw_o   (s2_raw),
        .cb_vld_o   (cb_vld),
        .cb_addr_o  (cb_addr),
        .cb_mask_o  (cb_mask),
        .cb_data_o  (cb_data),
        .out_rd_o   (out_rd),
        .out_data_o (out_data)
    );

    assign rdata       = out_data;
    assign rdata_drive = out_rd && !oe_n;

    // R7: stalled edges keep the visible output registers
    assert_stall_output_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(out_rd)));

endmodule

// File: tb/zbt_sram_core_bench.sv
module zbt_sram_core_bench;

    localparam int DEPTH  = 64;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int AW     = 6;
    localparam int W      = 36;

    localparam logic [1:0] K_IDLE  = 2'b00;
    localparam logic [1:0] K_READ  = 2'b01;
    localparam logic [1:0] K_WRITE = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b1;
    logic [1:0]       op = K_IDLE;
    logic [AW-1:0]    addr = '0;
    logic [LANES-1:0] bwe_n = '1;
    logic [W-1:0]     wdata = '0;
    logic             oe_n = 1'b0;
    logic [W-1:0]     rdata;
    logic             rdata_drive;

    always #4 clk = ~clk;

    zbt_sram_core u_zbt_sram_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .op         (op),
        .addr       (addr),
        .bwe_n      (bwe_n),
        .wdata      (wdata),
        .oe_n       (oe_n),
        .rdata      (rdata),
        .rdata_drive(rdata_drive)
    );

    int checks = 0;
    int errors = 0;

    logic [W-1:0] mem_m [DEPTH];
    logic [W-1:0] wpipe0 = '0, wpipe1 = '0;

    bit           exp_rd_q  [$];
    logic [W-1:0] exp_dat_q [$];
    string        exp_tag_q [$];

    bit           edge_en = 1'b0;
    bit           mon_on = 1'b0;
    logic [W-1:0] last_rdata;
    logic         last_drive;

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom(), $urandom()});
    endfunction

    // driver: one bus slot per call; pushes the expectation for the slot
    task automatic step(input logic [1:0] o, input int a, input logic [LANES-1:0] bn,
                        input logic [W-1:0] d, input bit en, input bit oen, input string tag);
        @(negedge clk);
        clk_en = en;
        oe_n   = oen;
        if (en) begin
            op    = o;
            addr  = AW'(a);
            bwe_n = bn;
            wdata = wpipe1;
        end else begin
            op    = 2'($urandom());
            addr  = AW'($urandom());
            bwe_n = 4'($urandom());
            wdata = rnd_word();
        end
        @(posedge clk);
        edge_en = en;
        if (en) begin
            exp_rd_q.push_back(o == K_READ);
            exp_dat_q.push_back(mem_m[a]);
            exp_tag_q.push_back(tag);
            if (o == K_WRITE) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!bn[l]) mem_m[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
                end
            end
            wpipe1 = wpipe0;
            wpipe0 = (o == K_WRITE) ? d : '0;
        end
    endtask

    task automatic wr(input int a, input logic [LANES-1:0] bn, input logic [W-1:0] d, input string tag);
        step(K_WRITE, a, bn, d, 1'b1, 1'b0, tag);
    endtask

    task automatic rd(input int a, input string tag);
        step(K_READ, a, '1, '0, 1'b1, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(K_IDLE, 0, '1, '0, 1'b1, 1'b0, tag);
    endtask

    task automatic stall(input int n, input bit oen, input string tag);
        for (int i = 0; i < n; i++) step(K_IDLE, 0, '1, '0, 1'b0, oen, tag);
    endtask

    // monitor: compares the output register against the scoreboard
    always @(posedge clk) begin
        if (mon_on) begin
            #2;
            if (edge_en) begin
                bit           e_rd;
                logic [W-1:0] e_dat;
                string        e_tag;
                e_rd  = exp_rd_q.pop_front();
                e_dat = exp_dat_q.pop_front();
                e_tag = exp_tag_q.pop_front();
                checks++;
                if (rdata_drive !== (e_rd && !oe_n)) begin
                    errors++;
                    $display("FAIL %s drive: actual %0b expected %0b", e_tag, rdata_drive, e_rd && !oe_n);
                end
                if (e_rd) begin
                    checks++;
                    if (rdata !== e_dat) begin
                        errors++;
                        $display("FAIL %s data: actual %h expected %h", e_tag, rdata, e_dat);
                    end
                end
            end else begin
                checks++;  // R7 output frozen while stalled
                if (rdata !== last_rdata || rdata_drive !== last_drive) begin
                    errors++;
                    $display("FAIL R7 stall: actual %h/%0b expected %h/%0b",
                             rdata, rdata_drive, last_rdata, last_drive);
                end
            end
            last_rdata = rdata;
            last_drive = rdata_drive;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;  // R10 reset leaves the output undriven
        if (rdata_drive !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset drive: actual %0b expected 0", rdata_drive);
        end
        // two slots already in flight at reset carry nothing
        for (int i = 0; i < 2; i++) begin
            exp_rd_q.push_back(1'b0);
            exp_dat_q.push_back('0);
            exp_tag_q.push_back("R10");
        end
        last_rdata = rdata;
        last_drive = rdata_drive;
        mon_on = 1'b1;

        // R10 unwritten word reads zero
        rd(5, "R10");
        rd(63, "R10");
        idle(2, "R8");

        // R1 R2 full-width writes then reads back
        for (int i = 0; i < 4; i++) wr(i, 4'b0000, rnd_word(), "R2");
        idle(4, "R8");
        for (int i = 0; i < 4; i++) rd(i, "R1");
        // R4 read directly after a write, no gap
        wr(9, 4'b0000, rnd_word(), "R4");
        rd(9, "R4");
        for (int g = 0; g < 4; g++) begin
            wr(10 + g, 4'b0000, rnd_word(), "R4");
            idle(g, "R4");
            rd(10 + g, "R4");
        end

        // R5 partial lane over an older full word, read at once and later
        wr(20, 4'b0000, rnd_word(), "R5");
        idle(4, "R5");
        wr(20, 4'b1101, rnd_word(), "R5");
        rd(20, "R5");
        idle(1, "R5");
        wr(20, 4'b0110, rnd_word(), "R5");
        idle(1, "R5");
        rd(20, "R5");
        idle(3, "R5");
        rd(20, "R5");

        // R6 two pending writes on one address
        wr(21, 4'b0000, rnd_word(), "R6");
        wr(21, 4'b0000, rnd_word(), "R6");
        rd(21, "R6");
        wr(22, 4'b0000, rnd_word(), "R6");
        idle(4, "R6");
        wr(22, 4'b1100, rnd_word(), "R6");
        wr(22, 4'b1001, rnd_word(), "R6");
        rd(22, "R6");
        idle(3, "R6");
        rd(22, "R6");

        // R3 write abort changes nothing, seen at once and after commit
        wr(0, 4'b1111, rnd_word(), "R3");
        rd(0, "R3");
        idle(4, "R3");
        rd(0, "R3");

        // R7 stall with garbage inputs while writes are pending
        wr(30, 4'b0000, rnd_word(), "R7");
        stall(3, 1'b0, "R7");
        wr(30, 4'b0011, rnd_word(), "R7");
        stall(2, 1'b0, "R7");
        rd(30, "R7");
        stall(3, 1'b0, "R7");
        idle(3, "R7");
        rd(30, "R7");

        // R9 dummy read: data loads, nothing driven
        step(K_READ, 2, '1, '0, 1'b1, 1'b1, "R9");
        step(K_IDLE, 0, '1, '0, 1'b1, 1'b1, "R9");
        step(K_IDLE, 0, '1, '0, 1'b1, 1'b1, "R9");
        rd(3, "R9");
        // R8 write then idle slots leave drive low
        wr(40, 4'b0000, rnd_word(), "R8");
        idle(3, "R8");

        // R4 mixed traffic on a small address window
        for (int i = 0; i < 600; i++) begin
            int          sel;
            int          a;
            logic [1:0]  o;
            sel = int'($urandom_range(0, 99));
            a   = int'($urandom_range(0, 7));
            o   = (sel < 45) ? K_READ : (sel < 85) ? K_WRITE : K_IDLE;
            if ($urandom_range(0, 9) == 0) begin
                step(K_IDLE, 0, '1, '0, 1'b0, oe_n, "R7");
            end else begin
                step(o, a, 4'($urandom()), rnd_word(), 1'b1,
                     ($urandom_range(0, 4) == 0), "R4");
            end
        end
        idle(3, "R8");
        mon_on = 1'b0;
        finish_run();
    end

endmodule